// File: doc/BRIEF.md
# TFT Raster Timing Controller

This block produces the line and frame timing for a 320x240 parallel-RGB TFT panel with 18-bit colour, 6 bits per primary. It runs on the pixel clock, so one pixel goes out per clock. A host programs every timing value through a byte-wide write port. After that, the block counts pixels and lines and drives active-low horizontal and vertical sync, a data-enable strobe and the 18-bit pixel bus. It also drives a copy of the pixel clock with selectable polarity, two static scan-direction straps and a lamp enable for the backlight.

Pixel data arrives on a streaming input. The block raises `pix_req` in each cycle whose raster position lies inside the visible window. The source presents a pixel in that same cycle, and the pixel reaches the panel one clock later with `de` high. Writes to timing registers go into pending copies. The live counters take them only at a frame boundary, so a frame never mixes two timings. Clock polarity, straps, blanking and the run/lamp controls take effect as soon as they are written.

Top module: `tft_raster_ctrl`

## Requirements
- R1: A synchronous reset drives `hsync_n`, `vsync_n` high, drives `de`, `pix_req`, `lamp_en`, `scan_vflip`, `scan_hflip` and `pix_out` low, and keeps the raster halted until the run bit is written.
- R2: A line lasts (N+1)*8 clocks, where N is the line-length byte at offset 0x00. A frame lasts V+1 lines, where V is the 10-bit frame-length value at offsets 0x08 and 0x09.
- R3: In every visible line `de` stays high for (A+1)*8 consecutive clocks, where A is the byte at offset 0x01. A frame has L+1 visible lines, where L is the 10-bit value at offsets 0x0A and 0x0B.
- R4: The first visible pixel of a line comes D clocks after the line start, with D at offsets 0x02 and 0x03. The first visible line comes S lines after the frame start, with S at offsets 0x0C and 0x0D.
- R5: `hsync_n` goes low at pixel P (offsets 0x05 and 0x06) for W+1 clocks, with W at 0x04. `vsync_n` goes low at line Q (offsets 0x0F and 0x10) for U+1 lines, with U at 0x0E.
- R6: `pix_req` is high in exactly the cycles whose raster position is visible. The 18-bit word on `pix_in` in that cycle appears unchanged on `pix_out` one clock later, together with `de`.
- R7: Bit 6 of the mode register at offset 0x1C blanks the image (0xC0 blanks, 0x80 shows). While blanked, syncs and `de` keep their timing and `pix_out` is all zeros.
- R8: Bit 0 of the control register at offset 0x18 inverts `pclk_out` relative to the internal clock. When the bit is 0, `pclk_out` follows the clock.
- R9: Control bits 1 and 2 drive `scan_vflip` and `scan_hflip` directly.
- R10: `lamp_en` is high only when control bit 3 is set and the run bit (mode bit 7) is set, and only after one full frame has completed since the raster started. When run is cleared, `lamp_en` falls within two clocks. The raster then finishes the current frame and halts with its outputs inactive.
- R11: A timing value written mid-frame has no effect on the rest of that frame. It takes effect from the next frame.
- R12: Each 10-bit value is split over two registers: bits 7..0 at the lower offset and bits 9..8 in bits 1..0 at the next offset. Both halves are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register offset |
| reg_wdata | input | 8 | Register write data |
| pix_req | output | 1 | Pixel wanted this cycle |
| pix_in | input | 18 | Streamed pixel, RGB 6:6:6 |
| pclk_out | output | 1 | Panel clock, polarity selectable |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable |
| pix_out | output | 18 | Pixel bus to panel |
| scan_vflip | output | 1 | Vertical scan direction strap |
| scan_hflip | output | 1 | Horizontal scan direction strap |
| lamp_en | output | 1 | Backlight enable |

## Verification
The two functions that meet in one cycle are a host write to a timing register and the frame-boundary load that copies pending values into the live counters. The bench narrows the visible width just after a vertical sync edge. It then measures one more line at the old width and the next frame at the new width. The second collision is clearing run while the raster is mid-frame: `lamp_en` must drop at once while `de` keeps pulsing for the remaining visible lines, and only then must every output go idle. Pixel words are tracked in a scoreboard queue, so a skew or a lost pixel at either collision is caught.

// File: rtl/tftc_pkg.sv
package tftc_pkg;

    localparam int PIX_W  = 18;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 6;
    localparam int VAL_W  = 10;
    localparam int HCNT_W = 11;
    localparam int VCNT_W = VAL_W;
    localparam int SUB_W  = HCNT_W - REG_W;
    localparam int HI_W   = VAL_W - REG_W;
    localparam int SPAN_W = 12;

    typedef struct packed {
        logic [REG_W-1:0] h_total8;
        logic [REG_W-1:0] h_act8;
        logic [VAL_W-1:0] h_start;
        logic [REG_W-1:0] hs_width;
        logic [VAL_W-1:0] hs_start;
        logic [VAL_W-1:0] v_total;
        logic [VAL_W-1:0] v_act;
        logic [VAL_W-1:0] v_start;
        logic [REG_W-1:0] vs_width;
        logic [VAL_W-1:0] vs_start;
    } tcfg_t;

    localparam logic [ADDR_W-1:0] A_HTOT   = 6'h00;
    localparam logic [ADDR_W-1:0] A_HACT   = 6'h01;
    localparam logic [ADDR_W-1:0] A_HDEL_L = 6'h02;
    localparam logic [ADDR_W-1:0] A_HDEL_H = 6'h03;
    localparam logic [ADDR_W-1:0] A_HSW    = 6'h04;
    localparam logic [ADDR_W-1:0] A_HSS_L  = 6'h05;
    localparam logic [ADDR_W-1:0] A_HSS_H  = 6'h06;
    localparam logic [ADDR_W-1:0] A_VTOT_L = 6'h08;
    localparam logic [ADDR_W-1:0] A_VTOT_H = 6'h09;
    localparam logic [ADDR_W-1:0] A_VACT_L = 6'h0A;
    localparam logic [ADDR_W-1:0] A_VACT_H = 6'h0B;
    localparam logic [ADDR_W-1:0] A_VDEL_L = 6'h0C;
    localparam logic [ADDR_W-1:0] A_VDEL_H = 6'h0D;
    localparam logic [ADDR_W-1:0] A_VSW    = 6'h0E;
    localparam logic [ADDR_W-1:0] A_VSS_L  = 6'h0F;
    localparam logic [ADDR_W-1:0] A_VSS_H  = 6'h10;
    localparam logic [ADDR_W-1:0] A_CTRL   = 6'h18;
    localparam logic [ADDR_W-1:0] A_MODE   = 6'h1C;

    // Position lies in the half-open span [lo, lo + len)
    function automatic logic in_span(input logic [SPAN_W-1:0] pos,
                                     input logic [SPAN_W-1:0] lo,
                                     input logic [SPAN_W-1:0] len);
        return (pos >= lo) && (pos < (lo + len));
    endfunction

endpackage

// File: rtl/tftc_regfile.sv
module tftc_regfile
    import tftc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output tcfg_t             cfg_pend,
    output logic              clk_inv,
    output logic              vflip,
    output logic              hflip,
    output logic              lamp_req,
    output logic              run,
    output logic              blank
);

    localparam int CTRL_W = 4;

    // Power-on timing suits a 408x262 raster with a 320x240 window
    localparam tcfg_t CFG_RESET = '{
        h_total8: 8'd50,  h_act8:   8'd39,  h_start:  10'd68,
        hs_width: 8'd29,  hs_start: 10'd0,  v_total:  10'd261,
        v_act:    10'd239, v_start: 10'd18, vs_width: 8'd2,
        vs_start: 10'd1
    };

    typedef struct packed {
        tcfg_t             cfg;
        logic [CTRL_W-1:0] ctrl;
        logic              run;
        logic              blank;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d = rf_q;
        if (we) begin
            case (addr)
                A_HTOT:   rf_d.cfg.h_total8                = wdata;
                A_HACT:   rf_d.cfg.h_act8                  = wdata;
                A_HDEL_L: rf_d.cfg.h_start[REG_W-1:0]      = wdata;
                A_HDEL_H: rf_d.cfg.h_start[VAL_W-1:REG_W]  = wdata[HI_W-1:0];
                A_HSW:    rf_d.cfg.hs_width                = wdata;
                A_HSS_L:  rf_d.cfg.hs_start[REG_W-1:0]     = wdata;
                A_HSS_H:  rf_d.cfg.hs_start[VAL_W-1:REG_W] = wdata[HI_W-1:0];
                A_VTOT_L: rf_d.cfg.v_total[REG_W-1:0]      = wdata;
                A_VTOT_H: rf_d.cfg.v_total[VAL_W-1:REG_W]  = wdata[HI_W-1:0];
                A_VACT_L: rf_d.cfg.v_act[REG_W-1:0]        = wdata;
                A_VACT_H: rf_d.cfg.v_act[VAL_W-1:REG_W]    = wdata[HI_W-1:0];
                A_VDEL_L: rf_d.cfg.v_start[REG_W-1:0]      = wdata;
                A_VDEL_H: rf_d.cfg.v_start[VAL_W-1:REG_W]  = wdata[HI_W-1:0];
                A_VSW:    rf_d.cfg.vs_width                = wdata;
                A_VSS_L:  rf_d.cfg.vs_start[REG_W-1:0]     = wdata;
                A_VSS_H:  rf_d.cfg.vs_start[VAL_W-1:REG_W] = wdata[HI_W-1:0];
                A_CTRL:   rf_d.ctrl                        = wdata[CTRL_W-1:0];
                A_MODE: begin
                    rf_d.run   = wdata[7];
                    rf_d.blank = wdata[6];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rf_q <= '{cfg: CFG_RESET, ctrl: '0, run: 1'b0, blank: 1'b0};
        end else begin
            rf_q <= rf_d;
        end
    end

    assign cfg_pend = rf_q.cfg;
    assign clk_inv  = rf_q.ctrl[0];
    assign vflip    = rf_q.ctrl[1];
    assign hflip    = rf_q.ctrl[2];
    assign lamp_req = rf_q.ctrl[3];
    assign run      = rf_q.run;
    assign blank    = rf_q.blank;

endmodule

// File: rtl/tftc_scan.sv
module tftc_scan
    import tftc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  tcfg_t             cfg_pend,
    output tcfg_t             cfg_live,
    output logic [HCNT_W-1:0] h_pos,
    output logic [VCNT_W-1:0] v_pos,
    output logic              running,
    output logic              seen,
    output logic              load
);

    typedef struct packed {
        logic              running;
        logic              seen;
        logic [HCNT_W-1:0] h;
        logic [VCNT_W-1:0] v;
        tcfg_t             cfg;
    } scan_t;

    scan_t s_d, s_q;
    logic [HCNT_W-1:0] h_last;

    assign h_last = {s_q.cfg.h_total8, {SUB_W{1'b1}}};

    always_comb begin
        s_d  = s_q;
        load = 1'b0;
        if (!s_q.running) begin
            if (run) begin
                s_d.running = 1'b1;
                s_d.h       = '0;
                s_d.v       = '0;
                s_d.cfg     = cfg_pend;
                load        = 1'b1;
            end
        end else if (s_q.h == h_last) begin
            s_d.h = '0;
            if (s_q.v == s_q.cfg.v_total) begin
                s_d.v = '0;
                if (run) begin
                    s_d.seen = 1'b1;
                    s_d.cfg  = cfg_pend;
                    load     = 1'b1;
                end else begin
                    s_d.running = 1'b0;
                    s_d.seen    = 1'b0;
                end
            end else begin
                s_d.v = s_q.v + 1'b1;
            end
        end else begin
            s_d.h = s_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q.running <= 1'b0;
            s_q.seen    <= 1'b0;
            s_q.h       <= '0;
            s_q.v       <= '0;
            s_q.cfg     <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cfg_live = s_q.cfg;
    assign h_pos    = s_q.h;
    assign v_pos    = s_q.v;
    assign running  = s_q.running;
    assign seen     = s_q.seen;

endmodule

// File: rtl/tftc_window.sv
module tftc_window
    import tftc_pkg::*;
(
    input  logic [HCNT_W-1:0] h_pos,
    input  logic [VCNT_W-1:0] v_pos,
    input  tcfg_t             cfg,
    output logic              vid_on,
    output logic              hs_on,
    output logic              vs_on
);

    localparam logic [SPAN_W-1:0] ONE   = SPAN_W'(1);
    localparam logic [SPAN_W-1:0] GROUP = ONE << SUB_W;

    logic [SPAN_W-1:0] hp, vp, h_len;

    always_comb begin
        hp     = SPAN_W'(h_pos);
        vp     = SPAN_W'(v_pos);
        h_len  = SPAN_W'({cfg.h_act8, {SUB_W{1'b0}}}) + GROUP;
        vid_on = in_span(hp, SPAN_W'(cfg.h_start), h_len)
              && in_span(vp, SPAN_W'(cfg.v_start), SPAN_W'(cfg.v_act) + ONE);
        hs_on  = in_span(hp, SPAN_W'(cfg.hs_start), SPAN_W'(cfg.hs_width) + ONE);
        vs_on  = in_span(vp, SPAN_W'(cfg.vs_start), SPAN_W'(cfg.vs_width) + ONE);
    end

endmodule

// File: rtl/tft_raster_ctrl.sv
module tft_raster_ctrl
    import tftc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic              pix_req,
    input  logic [PIX_W-1:0]  pix_in,
    output logic              pclk_out,
    output logic              hsync_n,
    output logic              vsync_n,
    output logic              de,
    output logic [PIX_W-1:0]  pix_out,
    output logic              scan_vflip,
    output logic              scan_hflip,
    output logic              lamp_en
);

    typedef struct packed {
        logic             hs_n;
        logic             vs_n;
        logic             de;
        logic [PIX_W-1:0] pix;
        logic             lamp;
    } out_t;

    localparam out_t OUT_IDLE = '{hs_n: 1'b1, vs_n: 1'b1, de: 1'b0,
                                  pix: '0, lamp: 1'b0};

    tcfg_t             cfg_pend, cfg_live;
    logic              clk_inv, lamp_req, run, blank;
    logic [HCNT_W-1:0] h_pos;
    logic [VCNT_W-1:0] v_pos;
    logic              running, seen, load;
    logic              vid_on, hs_on, vs_on;
    out_t              out_d, out_q;

    tftc_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .cfg_pend (cfg_pend),
        .clk_inv  (clk_inv),
        .vflip    (scan_vflip),
        .hflip    (scan_hflip),
        .lamp_req (lamp_req),
        .run      (run),
        .blank    (blank)
    );

    tftc_scan u_scan (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .cfg_pend (cfg_pend),
        .cfg_live (cfg_live),
        .h_pos    (h_pos),
        .v_pos    (v_pos),
        .running  (running),
        .seen     (seen),
        .load     (load)
    );

    tftc_window u_win (
        .h_pos  (h_pos),
        .v_pos  (v_pos),
        .cfg    (cfg_live),
        .vid_on (vid_on),
        .hs_on  (hs_on),
        .vs_on  (vs_on)
    );

    assign pix_req = running && vid_on;

    always_comb begin
        out_d = OUT_IDLE;
        if (running) begin
            out_d.hs_n = !hs_on;
            out_d.vs_n = !vs_on;
            out_d.de   = vid_on;
            if (vid_on && !blank) begin
                out_d.pix = pix_in;
            end
        end
        out_d.lamp = lamp_req && run && seen && running;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= OUT_IDLE;
        end else begin
            out_q <= out_d;
        end
    end

    assign hsync_n  = out_q.hs_n;
    assign vsync_n  = out_q.vs_n;
    assign de       = out_q.de;
    assign pix_out  = out_q.pix;
    assign lamp_en  = out_q.lamp;
    assign pclk_out = clk ^ clk_inv;

endmodule

// File: rtl/tftc_checker.sv
module tftc_checker
    import tftc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             de,
    input logic             pix_req,
    input logic [PIX_W-1:0] pix_out,
    input logic             hsync_n,
    input logic             vsync_n,
    input logic             lamp_en,
    input logic             blank,
    input logic             running,
    input logic             seen,
    input logic             load,
    input tcfg_t            cfg_live
);

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (hsync_n && vsync_n && !de && !lamp_en && pix_out == '0));

    a_r6_de_after_req: assert property (@(posedge clk) disable iff (rst)
        de |-> $past(pix_req));

    a_r7_blank_black: assert property (@(posedge clk) disable iff (rst)
        (de && $past(blank)) |-> (pix_out == '0));

    a_r10_lamp_after_frame: assert property (@(posedge clk) disable iff (rst)
        lamp_en |-> $past(running && seen));

    a_r11_cfg_at_boundary: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cfg_live));

    a_r4_de_in_raster: assert property (@(posedge clk) disable iff (rst)
        de |-> $past(running));

endmodule

bind tft_raster_ctrl tftc_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .de       (de),
    .pix_req  (pix_req),
    .pix_out  (pix_out),
    .hsync_n  (hsync_n),
    .vsync_n  (vsync_n),
    .lamp_en  (lamp_en),
    .blank    (blank),
    .running  (running),
    .seen     (seen),
    .load     (load),
    .cfg_live (cfg_live)
);

// File: tb/tft_raster_ctrl_bench.sv
`timescale 1ns/1ps
module tft_raster_ctrl_bench;
    import tftc_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic              pix_req;
    logic [PIX_W-1:0]  pix_in = '0;
    logic              pclk_out, hsync_n, vsync_n, de;
    logic [PIX_W-1:0]  pix_out;
    logic              scan_vflip, scan_hflip, lamp_en;

    always #2 clk = ~clk;

    tft_raster_ctrl u_tft_raster_ctrl (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .pix_req(pix_req), .pix_in(pix_in),
        .pclk_out(pclk_out), .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de),
        .pix_out(pix_out), .scan_vflip(scan_vflip), .scan_hflip(scan_hflip),
        .lamp_en(lamp_en)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    // Scoreboard: driver side pushes, monitor side pops
    logic [PIX_W-1:0] exp_q[$];
    logic [PIX_W-1:0] next_pix = 18'h00155;
    bit blank_mode = 1'b0;

    // Measurements
    longint cyc = 0;
    longint hs_fall_t = 0, vs_fall_t = 0, de_rise_t = 0;
    longint line_per = 0, hs_wid = 0, de_wid = 0, de_off = 0;
    longint frame_per = 0, vs_wid = 0, vde_off = 0;
    int de_lines = 0, lines_last = 0, vs_count = 0, de_fall_cnt = 0;
    bit first_de = 1'b0;
    logic p_hs = 1'b1, p_vs = 1'b1, p_de = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            // monitor: compare delivered pixel with oldest expectation
            if (de) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, blank_mode ? "R7" : "R6", "pixel with empty queue", pix_out, 0);
                end else begin
                    logic [PIX_W-1:0] e;
                    e = exp_q.pop_front();
                    check(pix_out == e, blank_mode ? "R7" : "R6", "pixel value", pix_out, e);
                end
            end
            // driver: answer a request and record what must come out
            if (pix_req) begin
                pix_in = next_pix;
                exp_q.push_back(blank_mode ? '0 : next_pix);
                next_pix = next_pix + 18'd4099;
            end
            if (p_hs && !hsync_n) begin line_per = cyc - hs_fall_t; hs_fall_t = cyc; end
            if (!p_hs && hsync_n) hs_wid = cyc - hs_fall_t;
            if (!p_de && de) begin
                de_off = cyc - hs_fall_t; de_rise_t = cyc; de_lines++;
                if (first_de) begin vde_off = cyc - vs_fall_t; first_de = 1'b0; end
            end
            if (p_de && !de) begin de_wid = cyc - de_rise_t; de_fall_cnt++; end
            if (p_vs && !vsync_n) begin
                frame_per = cyc - vs_fall_t; vs_fall_t = cyc;
                lines_last = de_lines; de_lines = 0; first_de = 1'b1; vs_count++;
            end
            if (!p_vs && vsync_n) vs_wid = cyc - vs_fall_t;
            p_hs = hsync_n; p_vs = vsync_n; p_de = de;
        end
    end

    task automatic wait_frames(input int n);
        int t;
        t = vs_count;
        wait (vs_count >= t + n);
    endtask

    task automatic wait_de_fall();
        int t;
        t = de_fall_cnt;
        wait (de_fall_cnt > t);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(hsync_n && vsync_n, "R1", "syncs idle high", {hsync_n, vsync_n}, 3);
        check(!de && !pix_req && pix_out == '0, "R1", "data idle", de + pix_req, 0);
        check(!lamp_en && !scan_vflip && !scan_hflip, "R1", "lamp/straps low",
              {lamp_en, scan_vflip, scan_hflip}, 0);

        // small raster: 32 clocks x 10 lines
        wr(A_HTOT, 8'd3);   wr(A_HACT, 8'd1);
        wr(A_HDEL_L, 8'd10); wr(A_HDEL_H, 8'd0);
        wr(A_HSW, 8'd2);    wr(A_HSS_L, 8'd0);  wr(A_HSS_H, 8'd0);
        wr(A_VTOT_L, 8'd9); wr(A_VTOT_H, 8'd0);
        wr(A_VACT_L, 8'd3); wr(A_VACT_H, 8'd0);
        wr(A_VDEL_L, 8'd4); wr(A_VDEL_H, 8'd0);
        wr(A_VSW, 8'd1);    wr(A_VSS_L, 8'd1);  wr(A_VSS_H, 8'd0);
        repeat (20) @(negedge clk);
        check(hsync_n && !de, "R1", "halted before run", hsync_n, 1);
        wr(A_CTRL, 8'h08);
        wr(A_MODE, 8'h80);

        // R10: lamp held off through the first frame
        begin
            int lit;
            lit = 0;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                if (lamp_en) lit++;
            end
            check(lit == 0, "R10", "lamp during first frame", lit, 0);
        end
        repeat (100) @(negedge clk);
        check(lamp_en, "R10", "lamp after first frame", lamp_en, 1);

        wait_frames(3);
        check(line_per == 32, "R2", "line period", line_per, 32);
        check(frame_per == 320, "R2", "frame period", frame_per, 320);
        check(de_wid == 16, "R3", "de width", de_wid, 16);
        check(lines_last == 4, "R3", "visible lines", lines_last, 4);
        check(de_off == 10, "R4", "horizontal offset", de_off, 10);
        check(vde_off == 106, "R4", "vertical offset", vde_off, 106);
        check(hs_wid == 3, "R5", "hsync width", hs_wid, 3);
        check(vs_wid == 64, "R5", "vsync width", vs_wid, 64);

        // R8: clock polarity
        @(negedge clk); #1;
        check(pclk_out == 1'b0, "R8", "pclk follows clk", pclk_out, 0);
        wr(A_CTRL, 8'h09);
        #1;
        check(pclk_out == 1'b1, "R8", "pclk inverted at low clk", pclk_out, 1);
        @(posedge clk); #1;
        check(pclk_out == 1'b0, "R8", "pclk inverted at high clk", pclk_out, 0);

        // R9: straps
        wr(A_CTRL, 8'h0A);
        check(scan_vflip && !scan_hflip, "R9", "vertical strap", {scan_vflip, scan_hflip}, 2);
        wr(A_CTRL, 8'h0C);
        check(!scan_vflip && scan_hflip, "R9", "horizontal strap", {scan_vflip, scan_hflip}, 1);
        wr(A_CTRL, 8'h08);

        // R7: blanking in vertical blank region
        wait_frames(1);
        wr(A_MODE, 8'hC0);
        blank_mode = 1'b1;
        wait_frames(2);
        check(lines_last == 4, "R7", "de kept while blanked", lines_last, 4);
        check(frame_per == 320, "R7", "frame kept while blanked", frame_per, 320);
        wr(A_MODE, 8'h80);
        blank_mode = 1'b0;

        // R11: width change lands only on next frame
        wait_frames(1);
        wr(A_HACT, 8'd0);
        wait_de_fall();
        check(de_wid == 16, "R11", "old width this frame", de_wid, 16);
        wait_frames(1);
        wait_de_fall();
        check(de_wid == 8, "R11", "new width next frame", de_wid, 8);
        wr(A_HACT, 8'd1);
        wait_frames(2);

        // R12: 10-bit frame length split over two registers
        wr(A_VTOT_L, 8'h05);
        wr(A_VTOT_H, 8'h01);
        wait_frames(2);
        check(frame_per == 8384, "R12", "262-line frame", frame_per, 8384);
        wr(A_VTOT_L, 8'd9);
        wr(A_VTOT_H, 8'd0);
        wait_frames(2);
        check(frame_per == 320, "R12", "restored frame", frame_per, 320);

        // R10: shutdown order
        wait_frames(1);
        begin
            int f0, lit;
            wr(A_MODE, 8'h00);
            f0 = de_fall_cnt;
            repeat (2) @(negedge clk);
            check(!lamp_en, "R10", "lamp off after run cleared", lamp_en, 0);
            repeat (400) @(negedge clk);
            check(de_fall_cnt - f0 == 4, "R10", "lines finished after lamp off",
                  de_fall_cnt - f0, 4);
            lit = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (!hsync_n || !vsync_n || de || lamp_en || pix_req) lit++;
            end
            check(lit == 0, "R10", "outputs idle after halt", lit, 0);
        end
        check(exp_q.size() == 0, "R6", "scoreboard drained", exp_q.size(), 0);
        finish_run();
    end

endmodule